// File: doc/BRIEF.md
# Sync Word Lock Tracker

This block follows two streams of sync-word detections, one for audio frames and one for transport packets, and reports how far each stream has come towards lock. Each stream has its own three-state tracker: searching, awaiting confirmation, and synchronized. An upstream detector sends a one-cycle pulse for every sync word it finds, and a separate one-cycle pulse when it loses sync. Each tracker has its own programmable lock threshold.

The host sees both 2-bit state codes packed into one read-only status byte. A sticky interrupt flag is raised whenever either code changes. A read strobe on the status byte clears the flag, unless a new change lands in the same cycle as the read.

Top module: `sync_lock_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both trackers return to searching (code 00), their confirmation counts clear, and `sync_irq_o` clears. After reset, `status_o` reads 0 and `sync_irq_o` reads 0.
- R2: A sync pulse that arrives while a tracker is searching moves it to awaiting confirmation (code 01) at that clock edge. The tracker's confirmation count starts at zero.
- R3: While a tracker awaits confirmation, it counts its sync pulses. The pulse that brings the count to threshold+1 moves the tracker to synchronized (code 10). With threshold 0, the first pulse after entering confirmation locks. With threshold 255, the 256th pulse locks.
- R4: A loss pulse while a tracker awaits confirmation or is synchronized returns it to searching and clears its count. A later attempt at lock needs the full number of sync pulses again.
- R5: Some pulses have no effect. A loss pulse while searching, and a sync pulse while synchronized, leave the status code and the interrupt flag unchanged.
- R6: Code 11 never appears in either status field.
- R7: The frame tracker state is in `status_o[1:0]` and the packet tracker state is in `status_o[3:2]`. All higher bits read 0.
- R8: `sync_irq_o` is set at the clock edge on which either status code changes. It stays set until it is cleared.
- R9: A cycle with `stat_rd_i` high clears `sync_irq_o` at that edge. If a status code changes at the same edge, the flag is set instead.
- R10: The two trackers are independent. Pulses and thresholds for one tracker never alter the other tracker's field.
- R11: When a sync pulse and a loss pulse reach one tracker in the same cycle, the result depends on the state. While searching, the sync pulse acts and the loss pulse is ignored. Otherwise, the loss pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_sync_i | input | 1 | One-cycle pulse: frame sync word detected |
| pkt_sync_i | input | 1 | One-cycle pulse: packet sync word detected |
| frm_loss_i | input | 1 | One-cycle pulse: frame sync lost |
| pkt_loss_i | input | 1 | One-cycle pulse: packet sync lost |
| frm_thr_i | input | THR_W | Frame lock threshold |
| pkt_thr_i | input | THR_W | Packet lock threshold |
| stat_rd_i | input | 1 | Host read strobe of the status byte |
| status_o | output | STAT_W | {zeros, packet code, frame code} |
| sync_irq_o | output | 1 | Sticky sync-status interrupt |

## Verification
The assertions assume four things about the inputs:
- every pulse input is low while `rst_n` is low;
- reset is held for at least two edges;
- `frm_thr_i` is held steady while the frame tracker is confirming;
- `pkt_thr_i` is held steady while the packet tracker is confirming.

The stimulus respects these assumptions. It changes a threshold only right after a reset, or after forcing that tracker back to searching with a loss pulse. It drives pulses only after reset has been released. The random phase draws thresholds from a small range so that lock and loss both happen often.

// File: rtl/slt_pkg.sv
package slt_pkg;
   typedef enum logic [1:0] {
      ST_SEARCH  = 2'b00,
      ST_CONFIRM = 2'b01,
      ST_LOCKED  = 2'b10
   } trk_state_e;

   localparam int unsigned CODE_W     = 2;
   localparam int unsigned N_TRK      = 2;
   localparam int unsigned TRK_FRAME  = 0;
   localparam int unsigned TRK_PACKET = 1;
endpackage

// File: rtl/slt_tracker.sv
module slt_tracker
   import slt_pkg::*;
#(
   parameter int unsigned THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             loss_i,
   input  logic [THR_W-1:0] thr_i,
   output trk_state_e       state_o,
   output logic             change_o
);
   trk_state_e       state_q, state_d;
   logic [THR_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_SEARCH: begin
            if (sync_i) begin
               state_d = ST_CONFIRM;
               cnt_d   = '0;
            end
         end
         ST_CONFIRM: begin
            if (loss_i) begin
               state_d = ST_SEARCH;
               cnt_d   = '0;
            end else if (sync_i) begin
               if (cnt_q >= thr_i) begin
                  state_d = ST_LOCKED;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_LOCKED: begin
            if (loss_i) begin
               state_d = ST_SEARCH;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = ST_SEARCH;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SEARCH;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o  = state_q;
   assign change_o = (state_d != state_q);
endmodule

// File: rtl/slt_irq.sv
module slt_irq #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] change_i,
   input  logic             rd_i,
   output logic             irq_o
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (|change_i) | (irq_q & ~rd_i);
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/sync_lock_tracker.sv
module sync_lock_tracker
   import slt_pkg::*;
#(
   parameter int unsigned THR_W  = 8,
   parameter int unsigned STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_sync_i,
   input  logic              pkt_sync_i,
   input  logic              frm_loss_i,
   input  logic              pkt_loss_i,
   input  logic [THR_W-1:0]  frm_thr_i,
   input  logic [THR_W-1:0]  pkt_thr_i,
   input  logic              stat_rd_i,
   output logic [STAT_W-1:0] status_o,
   output logic              sync_irq_o
);
   localparam int unsigned FIELDS_W = N_TRK * CODE_W;

   if (THR_W < 1) begin : g_bad_thr
      $error("THR_W must be at least 1");
   end
   if (STAT_W < FIELDS_W) begin : g_bad_stat
      $error("STAT_W too narrow for both status fields");
   end

   logic [N_TRK-1:0] sync_v, loss_v, change_v;
   logic [THR_W-1:0] thr_v [N_TRK];
   trk_state_e       st_v  [N_TRK];

   assign sync_v[TRK_FRAME]  = frm_sync_i;
   assign sync_v[TRK_PACKET] = pkt_sync_i;
   assign loss_v[TRK_FRAME]  = frm_loss_i;
   assign loss_v[TRK_PACKET] = pkt_loss_i;
   assign thr_v[TRK_FRAME]   = frm_thr_i;
   assign thr_v[TRK_PACKET]  = pkt_thr_i;

   for (genvar i = 0; i < N_TRK; i++) begin : g_trk
      slt_tracker #(.THR_W(THR_W)) u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_i   (sync_v[i]),
         .loss_i   (loss_v[i]),
         .thr_i    (thr_v[i]),
         .state_o  (st_v[i]),
         .change_o (change_v[i])
      );
      assign status_o[i*CODE_W +: CODE_W] = st_v[i];
   end

   if (STAT_W > FIELDS_W) begin : g_pad
      assign status_o[STAT_W-1:FIELDS_W] = '0;
   end

   slt_irq #(.N_SRC(N_TRK)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .change_i (change_v),
      .rd_i     (stat_rd_i),
      .irq_o    (sync_irq_o)
   );
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
   parameter int unsigned THR_W  = 8,
   parameter int unsigned STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_sync_i,
   input logic              pkt_sync_i,
   input logic              frm_loss_i,
   input logic              pkt_loss_i,
   input logic [THR_W-1:0]  frm_thr_i,
   input logic [THR_W-1:0]  pkt_thr_i,
   input logic              stat_rd_i,
   input logic [STAT_W-1:0] status_o,
   input logic              sync_irq_o
);
   a_r6_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1:0] != 2'b11) && (status_o[3:2] != 2'b11));

   a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o >> 4) == '0);

   a_r2_frm_enter_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1:0] == 2'b00 && frm_sync_i) |=> (status_o[1:0] == 2'b01));

   a_r2_pkt_enter_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[3:2] == 2'b00 && pkt_sync_i) |=> (status_o[3:2] == 2'b01));

   a_r4_frm_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1:0] != 2'b00 && frm_loss_i) |=> (status_o[1:0] == 2'b00));

   a_r4_pkt_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[3:2] != 2'b00 && pkt_loss_i) |=> (status_o[3:2] == 2'b00));

   a_r5_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1:0] == 2'b10 && !frm_loss_i) |=> (status_o[1:0] == 2'b10));

   a_r8_change_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o != $past(status_o)) |-> sync_irq_o);

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_rd_i) && status_o == $past(status_o)) |-> !sync_irq_o);
endmodule

bind sync_lock_tracker slt_checker #(.THR_W(THR_W), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/tb_sync_lock_tracker.sv
`timescale 1ns/1ps
module tb_sync_lock_tracker;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_sync_i = 0, pkt_sync_i = 0, frm_loss_i = 0, pkt_loss_i = 0;
   logic [7:0] frm_thr_i = 0, pkt_thr_i = 0;
   logic       stat_rd_i = 0;
   logic [7:0] status_o;
   logic       sync_irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [1:0] fst, pst;
   int         fcnt, pcnt;
   bit         irq_m;

   always #2 clk = ~clk;

   sync_lock_tracker dut (.*);

   function automatic void trk_next(inout logic [1:0] st, inout int cnt,
                                    input bit sync, input bit loss,
                                    input int thr, output bit chg);
      logic [1:0] old = st;
      case (st)
         2'b00: if (sync) begin st = 2'b01; cnt = 0; end
         2'b01: if (loss) begin st = 2'b00; cnt = 0; end
                else if (sync) begin
                   if (cnt >= thr) begin st = 2'b10; cnt = 0; end
                   else cnt = cnt + 1;
                end
         default: if (loss) begin st = 2'b00; cnt = 0; end
      endcase
      chg = (st != old);
   endfunction

   task automatic check(input string tag);
      logic [7:0] exp_s = {4'b0, pst, fst};
      checks++;
      if (status_o !== exp_s || sync_irq_o !== irq_m) begin
         errors++;
         $display("FAIL %s: status=%h irq=%0b expected status=%h irq=%0b",
                  tag, status_o, sync_irq_o, exp_s, irq_m);
      end
      if (status_o[1:0] == 2'b11 || status_o[3:2] == 2'b11) begin
         errors++;
         $display("FAIL R6: status=%h expected no 11 field", status_o);
      end
   endtask

   task automatic step(input bit fs, input bit ps, input bit fl, input bit pl,
                       input bit rd, input string tag);
      bit c0, c1;
      @(negedge clk);
      frm_sync_i = fs; pkt_sync_i = ps; frm_loss_i = fl; pkt_loss_i = pl;
      stat_rd_i = rd;
      @(posedge clk);
      #1;
      trk_next(fst, fcnt, fs, fl, int'(frm_thr_i), c0);
      trk_next(pst, pcnt, ps, pl, int'(pkt_thr_i), c1);
      irq_m = c0 | c1 | (irq_m & ~rd);
      frm_sync_i = 0; pkt_sync_i = 0; frm_loss_i = 0; pkt_loss_i = 0;
      stat_rd_i = 0;
      if (tag != "") check(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1;
      fst = 0; pst = 0; fcnt = 0; pcnt = 0; irq_m = 0;
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      fst = 0; pst = 0; fcnt = 0; pcnt = 0; irq_m = 0;
      frm_thr_i = 8'd0; pkt_thr_i = 8'd2;
      do_reset();
      check("R1 reset state");

      // R2, R8: first frame sync
      step(1, 0, 0, 0, 0, "R2 frame enter confirm, R8 irq set");
      step(0, 0, 0, 0, 1, "R9 read clears irq");
      // R3 threshold 0 locks on first sync in confirmation
      step(1, 0, 0, 0, 0, "R3 thr0 lock");
      step(0, 0, 0, 0, 1, "R9 read clears irq");
      // R5 sync ignored while locked, loss ignored while searching
      step(1, 0, 0, 0, 0, "R5 sync ignored when locked");
      step(0, 0, 0, 1, 0, "R5 loss ignored when searching");
      // R10 packet tracker walks independently, R7 field placement
      step(0, 1, 0, 0, 0, "R10 packet to confirm, R7 field bits");
      step(0, 1, 0, 0, 0, "R3 packet count 1");
      step(0, 1, 0, 0, 1, "R3 packet count 2");
      step(0, 1, 0, 0, 1, "R3 packet lock after thr+1, R9 set wins");
      step(0, 0, 0, 0, 1, "R9 read clears");
      // R4 loss from locked then relock needs full count
      step(0, 0, 0, 1, 0, "R4 packet loss from locked");
      step(0, 1, 0, 0, 0, "R4 packet reenter confirm");
      step(0, 1, 0, 0, 0, "R4 count 1");
      step(0, 0, 0, 1, 0, "R4 loss in confirm");
      step(0, 1, 0, 0, 0, "R4 reenter");
      step(0, 1, 0, 0, 0, "R4 count restarts");
      step(0, 1, 0, 0, 0, "R4 count restarts");
      step(0, 1, 0, 0, 0, "R4 relock after full count");
      // R11 simultaneous sync and loss
      step(1, 1, 1, 1, 1, "R11 loss wins when locked/confirming");
      step(0, 0, 0, 0, 1, "R9 read");
      step(1, 1, 1, 1, 0, "R11 sync wins when searching");
      // R3 max threshold
      do_reset();
      frm_thr_i = 8'd255;
      step(1, 0, 0, 0, 0, "R2 enter confirm");
      for (int i = 0; i < 255; i++) step(1, 0, 0, 0, 1, "");
      check("R3 thr255 still confirming after 255");
      step(1, 0, 0, 0, 0, "R3 thr255 lock on 256th");

      // random phase
      for (int blk = 0; blk < 20; blk++) begin
         do_reset();
         frm_thr_i = 8'($urandom_range(0, 5));
         pkt_thr_i = 8'($urandom_range(0, 5));
         for (int i = 0; i < 400; i++) begin
            bit fs = ($urandom_range(0, 99) < 30);
            bit ps = ($urandom_range(0, 99) < 30);
            bit fl = ($urandom_range(0, 99) < 4);
            bit pl = ($urandom_range(0, 99) < 4);
            bit rd = ($urandom_range(0, 99) < 20);
            step(fs, ps, fl, pl, rd, "R3,R4,R8,R9,R10 random");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule